// File: doc/BRIEF.md
# USB Endpoint Stall Control Register

This block is the software-visible control point that decides, endpoint by endpoint, whether a four-endpoint USB function answers the host with a STALL handshake. Software sets or clears one stall bit per endpoint through a small register bus. It uses the same bus to reach a second register that holds the DMA-enable bits for endpoints 1 and 2. The transaction engine does not look at the stall bits directly. It reads a per-endpoint stall-active output, and that output takes its new value only when a new transaction for that endpoint begins. A transfer already under way therefore finishes as it started.

Endpoint 0 has two special rules. When the function receives an 8-byte setup command, a one-cycle pulse clears the endpoint 0 stall bit, and this clear wins over a software write in the same cycle. While the setup-pending flag is high, software cannot set the endpoint 0 stall bit. A write of 1 to that bit is dropped, but a write of 0 still clears it. Upper bits that are not implemented read as 0, and any data written to them is discarded.

The register bus is a plain select/write-strobe interface with no handshake. A write completes in the cycle in which `bus_sel` and `bus_we` are both high. Read data is combinational from the stored state. No stream traffic passes through the block, so no valid/ready signalling or back-pressure applies.

Top module: `usb_ep_stall_reg`

## Requirements
- R1: After reset, both registers read 0x00 and all `ep_stall` outputs are 0.
- R2: A write at address 0 loads `bus_wdata` bit n into the stall bit of endpoint n, for n = 0..3. A 1 sets the bit and a 0 clears it. A read at address 0 returns the stall bits in bits 3:0.
- R3: Bits 7:4 of read data are always 0, and data written to those positions is discarded.
- R4: `ep_stall[n]` changes only in the cycle after a transaction start with `xact_ep` = n. It then takes the value of stall bit n as it was before that edge, so a write in the same cycle as the start takes effect only on the following transaction.
- R5: A `setup_rx` pulse clears the endpoint 0 stall bit by the next cycle and leaves the stall bits of endpoints 1 to 3 unchanged.
- R6: If `setup_rx` and a write of 1 to stall bit 0 occur in the same cycle, stall bit 0 ends up 0.
- R7: While `setup_pend` is 1, a write of 1 to stall bit 0 leaves that bit unchanged. A write of 0 still clears it, and bits 3:1 are written normally.
- R8: A write at address 1 loads bit 0 as the endpoint 1 DMA enable and bit 1 as the endpoint 2 DMA enable. `dma_en` drives these bits, and they read back in bits 1:0 with bits 7:2 reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access selected |
| bus_we | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 1 | 0 = stall register, 1 = DMA-enable register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 when not selected |
| setup_rx | input | 1 | One-cycle pulse: 8-byte setup command received |
| setup_pend | input | 1 | Setup-pending flag |
| xact_start | input | 1 | One-cycle pulse: new transaction begins |
| xact_ep | input | 2 | Endpoint of the starting transaction |
| ep_stall | output | 4 | Stall-active per endpoint, as seen by the transaction engine |
| dma_en | output | 2 | DMA enable: bit 0 endpoint 1, bit 1 endpoint 2 |

## Verification
The assertions assume that `xact_start` and `setup_rx` are single-cycle pulses, that `xact_ep` is valid whenever `xact_start` is high, and that `setup_pend` changes only between clock edges. The bench drives every input on the falling edge, holds each pulse for exactly one cycle and then returns it to 0, and sets `setup_pend` as a level inside the scenario that needs it. Same-cycle collisions between a write and `setup_rx`, and between a write and `xact_start`, are produced on purpose so that the priority rules are exercised.

// File: rtl/ep_stall_pkg.sv
package ep_stall_pkg;
  typedef enum logic {
    REG_STALL = 1'b0,
    REG_DMA   = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/ep_stall_bits.sv
module ep_stall_bits #(
  parameter int NUM_EP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [NUM_EP-1:0] wr_bits,
  input  logic              setup_rx,
  input  logic              setup_pend,
  output logic [NUM_EP-1:0] stall_q
);
  for (genvar i = 0; i < NUM_EP; i++) begin : g_bit
    if (i == 0) begin : g_ctl
      // control endpoint: hardware clear first, pending flag blocks a set
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          stall_q[i] <= 1'b0;
        else if (setup_rx)
          stall_q[i] <= 1'b0;
        else if (wr_en && !(setup_pend && wr_bits[i]))
          stall_q[i] <= wr_bits[i];
      end
    end else begin : g_data
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          stall_q[i] <= 1'b0;
        else if (wr_en)
          stall_q[i] <= wr_bits[i];
      end
    end
  end
endmodule

// File: rtl/ep_stall_sample.sv
module ep_stall_sample #(
  parameter int NUM_EP = 4,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xact_start,
  input  logic [IDX_W-1:0]  xact_ep,
  input  logic [NUM_EP-1:0] stall_q,
  output logic [NUM_EP-1:0] ep_stall
);
  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    logic hit;
    assign hit = xact_start && (xact_ep == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ep_stall[i] <= 1'b0;
      else if (hit)
        ep_stall[i] <= stall_q[i];
    end
  end
endmodule

// File: rtl/ep_dma_ctrl.sv
module ep_dma_ctrl #(
  parameter int NUM_DMA = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [NUM_DMA-1:0] wr_bits,
  output logic [NUM_DMA-1:0] dma_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      dma_en <= '0;
    else if (wr_en)
      dma_en <= wr_bits;
  end
endmodule

// File: rtl/usb_ep_stall_reg.sv
module usb_ep_stall_reg #(
  parameter int NUM_EP  = 4,
  parameter int NUM_DMA = 2,
  parameter int DATA_W  = 8,
  localparam int IDX_W  = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              setup_rx,
  input  logic              setup_pend,
  input  logic              xact_start,
  input  logic [IDX_W-1:0]  xact_ep,
  output logic [NUM_EP-1:0] ep_stall,
  output logic [NUM_DMA-1:0] dma_en
);
  import ep_stall_pkg::*;

  logic [NUM_EP-1:0] stall_q;
  logic              wr_stall;
  logic              wr_dma;
  logic              wdata_unused;

  assign wr_stall     = bus_sel && bus_we && (bus_addr == REG_STALL);
  assign wr_dma       = bus_sel && bus_we && (bus_addr == REG_DMA);
  assign wdata_unused = ^bus_wdata[DATA_W-1:NUM_EP];

  ep_stall_bits #(.NUM_EP(NUM_EP)) u_bits (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_stall),
    .wr_bits    (bus_wdata[NUM_EP-1:0]),
    .setup_rx   (setup_rx),
    .setup_pend (setup_pend),
    .stall_q    (stall_q)
  );

  ep_stall_sample #(.NUM_EP(NUM_EP), .IDX_W(IDX_W)) u_sample (
    .clk        (clk),
    .rst_n      (rst_n),
    .xact_start (xact_start),
    .xact_ep    (xact_ep),
    .stall_q    (stall_q),
    .ep_stall   (ep_stall)
  );

  ep_dma_ctrl #(.NUM_DMA(NUM_DMA)) u_dma (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_dma),
    .wr_bits (bus_wdata[NUM_DMA-1:0]),
    .dma_en  (dma_en)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      if (bus_addr == REG_STALL)
        bus_rdata[NUM_EP-1:0] = stall_q;
      else
        bus_rdata[NUM_DMA-1:0] = dma_en;
    end
  end
endmodule

// File: rtl/ep_stall_chk.sv
module ep_stall_chk #(
  parameter int NUM_EP = 4,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic              bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              setup_rx,
  input logic              setup_pend,
  input logic              xact_start,
  input logic [IDX_W-1:0]  xact_ep,
  input logic [NUM_EP-1:0] stall_q,
  input logic [NUM_EP-1:0] ep_stall
);
  logic wr0;
  assign wr0 = bus_sel && bus_we && !bus_addr;

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:NUM_EP] == '0); // R3

  AST_SETUP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    setup_rx |=> !stall_q[0]); // R6

  AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    setup_rx && !wr0 |=> stall_q[NUM_EP-1:1] == $past(stall_q[NUM_EP-1:1])); // R5

  AST_PEND_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    setup_pend && !stall_q[0] |=> !stall_q[0]); // R7

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !xact_start |=> $stable(ep_stall)); // R4

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    AST_STALL_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      xact_start && (xact_ep == IDX_W'(i)) |=> ep_stall[i] == $past(stall_q[i])); // R4
  end
endmodule

bind usb_ep_stall_reg ep_stall_chk #(.NUM_EP(NUM_EP), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_sel    (bus_sel),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata),
  .setup_rx   (setup_rx),
  .setup_pend (setup_pend),
  .xact_start (xact_start),
  .xact_ep    (xact_ep),
  .stall_q    (stall_q),
  .ep_stall   (ep_stall)
);

// File: tb/usb_ep_stall_reg_tb.sv
`timescale 1ns/1ps
module usb_ep_stall_reg_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_we = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       setup_rx = 1'b0, setup_pend = 1'b0, xact_start = 1'b0;
  logic [1:0] xact_ep = '0;
  logic [3:0] ep_stall;
  logic [1:0] dma_en;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  usb_ep_stall_reg u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .setup_rx(setup_rx), .setup_pend(setup_pend), .xact_start(xact_start),
    .xact_ep(xact_ep), .ep_stall(ep_stall), .dma_en(dma_en)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // one clock of activity, driven on the falling edge, then back to idle
  task automatic step(input logic we, input logic addr, input logic [7:0] d,
                      input logic srx, input logic xs, input logic [1:0] xe);
    @(negedge clk);
    bus_sel = we; bus_we = we; bus_addr = addr; bus_wdata = d;
    setup_rx = srx; xact_start = xs; xact_ep = xe;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; setup_rx = 1'b0; xact_start = 1'b0;
  endtask

  task automatic wr(input logic addr, input logic [7:0] d);
    step(1'b1, addr, d, 1'b0, 1'b0, 2'd0);
  endtask

  task automatic rd_chk(input string req, input logic addr, input logic [7:0] exp);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = addr;
    #1;
    chk(req, bus_rdata, exp);
    bus_sel = 1'b0;
  endtask

  task automatic t_reset;
    rd_chk("R1 stall reg", 1'b0, 8'h00);
    rd_chk("R1 dma reg", 1'b1, 8'h00);
    chk("R1 ep_stall", {4'h0, ep_stall}, 8'h00);
  endtask

  task automatic t_rw;
    wr(1'b0, 8'hFF);
    rd_chk("R3 reserved masked", 1'b0, 8'h0F);
    wr(1'b0, 8'hA5);
    rd_chk("R2 pattern 5", 1'b0, 8'h05);
    wr(1'b0, 8'h0A);
    rd_chk("R2 pattern A", 1'b0, 8'h0A);
    wr(1'b0, 8'h00);
    rd_chk("R2 clear", 1'b0, 8'h00);
  endtask

  task automatic t_dma;
    wr(1'b1, 8'hFF);
    rd_chk("R8 dma all", 1'b1, 8'h03);
    chk("R8 dma_en pins", {6'h0, dma_en}, 8'h03);
    wr(1'b1, 8'h02);
    chk("R8 ep2 only", {6'h0, dma_en}, 8'h02);
    rd_chk("R2 stall untouched by dma write", 1'b0, 8'h00);
    wr(1'b1, 8'h00);
  endtask

  task automatic t_setup_clear;
    wr(1'b0, 8'h0F);
    step(1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 2'd0);
    rd_chk("R5 ep0 cleared, others kept", 1'b0, 8'h0E);
    wr(1'b0, 8'h00);
  endtask

  task automatic t_priority;
    step(1'b1, 1'b0, 8'h03, 1'b1, 1'b0, 2'd0);
    rd_chk("R6 setup beats write", 1'b0, 8'h02);
    wr(1'b0, 8'h00);
  endtask

  task automatic t_pend;
    setup_pend = 1'b1;
    wr(1'b0, 8'h0F);
    rd_chk("R7 set ignored while pending", 1'b0, 8'h0E);
    setup_pend = 1'b0;
    wr(1'b0, 8'h01);
    setup_pend = 1'b1;
    wr(1'b0, 8'h00);
    rd_chk("R7 clear allowed while pending", 1'b0, 8'h00);
    setup_pend = 1'b0;
    wr(1'b0, 8'h01);
    rd_chk("R7 set after pending drops", 1'b0, 8'h01);
    wr(1'b0, 8'h00);
  endtask

  task automatic t_timing;
    wr(1'b0, 8'h04);
    chk("R4 no change before token", {4'h0, ep_stall}, 8'h00);
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 2'd1);
    chk("R4 other endpoint token", {4'h0, ep_stall}, 8'h00);
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 2'd2);
    chk("R4 ep2 token applies", {4'h0, ep_stall}, 8'h04);
    step(1'b1, 1'b0, 8'h0C, 1'b0, 1'b1, 2'd3);
    chk("R4 same-cycle write deferred", {4'h0, ep_stall}, 8'h04);
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 2'd3);
    chk("R4 next ep3 token applies", {4'h0, ep_stall}, 8'h0C);
    wr(1'b0, 8'h00);
    chk("R4 clear held until token", {4'h0, ep_stall}, 8'h0C);
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 2'd2);
    chk("R4 ep2 released", {4'h0, ep_stall}, 8'h08);
  endtask

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rw();
    t_dma();
    t_setup_clear();
    t_priority();
    t_pend();
    t_timing();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule